// File: doc/BRIEF.md
# Per-Core Prioritized Interrupt Acceptance Unit

This unit sits at the core end of an interrupt network. Interrupt messages come in on one message port, whether they were sent by a central distributor or by another core. Each message carries a priority from 1 (lowest) to 15 (highest). The unit keeps the accepted messages as pending. It offers the core the highest pending priority that may be delivered, and it records which priorities the core is servicing, including nested ones. Software controls the unit through a small write port. That port sets a task-priority threshold, signals that a service routine has finished, and turns delivery to the core on or off.

Acceptance and delivery are separate steps. A message is accepted only if its priority is above the task-priority threshold. Accepted priorities are held in a pending vector, and repeated messages at the same priority merge into one pending entry. A pending priority is delivered only when three conditions hold: it is above the threshold, it is above every priority in service, and the enable flag is set. When the core acknowledges, the offered priority moves from pending to in-service. A finish write then retires the highest in-service priority, so a lower routine that was preempted becomes the limit again.

Delivery is tracked by a three-state machine:
- QUIET: nothing can be delivered.
- ASSERT: a priority can be delivered and the request is raised.
- MASKED: a priority could be delivered, but the enable flag is clear.

The state is recomputed every cycle from the register contents that will hold after the clock edge. This gives the following named transitions:
- QUIET→ASSERT (arm)
- QUIET→MASKED (arm_held)
- ASSERT→MASKED (hold)
- MASKED→ASSERT (release)
- ASSERT→QUIET (drain)
- MASKED→QUIET (drain_held)

Top module: `irq_accept_unit`

## Requirements
- R1: After reset, irq_req is 0 and irq_prio is 0. The task-priority threshold resets to 0, the enable flag resets to 1, and nothing is pending or in service.
- R2: A message with msg_valid high and priority p is accepted only if p is strictly greater than the threshold. Any other message, including every message with p = 0, leaves no pending entry.
- R3: In the cycle after a message is accepted, irq_req is 1 and irq_prio shows the highest pending priority, provided that priority can be delivered.
- R4: When irq_ack is high while irq_req is 1, the offered priority leaves pending and enters service. A pending priority at or below the highest in-service priority is then not offered.
- R5: A pending priority above the highest in-service priority is offered at once, even while a lower routine is in service (preemption).
- R6: A write with wr_sel = 1 (finish) clears only the highest in-service priority. Pending priorities above the new highest in-service level then become deliverable.
- R7: A finish write while nothing is in service has no effect on later delivery.
- R8: A second message at a priority that is already pending merges with it. After one acknowledge and one finish, that priority is not offered again.
- R9: A write with wr_sel = 2 loads the enable flag from wr_data[0]. While the flag is 0, irq_req and irq_prio stay 0, messages are still accepted, and held priorities are offered once the flag returns to 1.
- R10: A write with wr_sel = 0 loads the threshold from wr_data. A pending priority at or below the new threshold is held rather than offered, and it is offered again when the threshold drops below it.
- R11: irq_ack has no effect while irq_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Incoming interrupt message strobe |
| msg_prio | input | 4 | Priority carried by the message (0 means none) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 threshold, 1 finish, 2 enable flag, 3 unused |
| wr_data | input | 4 | Write data (threshold value, or enable in bit 0) |
| irq_ack | input | 1 | Core accepts the offered priority |
| irq_req | output | 1 | Interrupt request toward the core |
| irq_prio | output | 4 | Offered priority while irq_req is 1, else 0 |

## Verification
The assertions assume that irq_ack is a single-cycle pulse and is meaningful only while irq_req is high. They also assume that a finish write and an acknowledge in the same cycle do not target the same level. The acknowledge-to-service property excludes any cycle that also carries a finish write. The stimulus keeps to these limits because every operation uses its own cycle. The stimulus also never sends a message at the level being acknowledged in that same cycle, so each expected request and offered priority follows from the requirements alone.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // delivery view of the pending/in-service state
    typedef enum logic [1:0] {
        DLV_QUIET  = 2'd0,
        DLV_ASSERT = 2'd1,
        DLV_MASKED = 2'd2
    } dlv_state_e;

    // targets of the register write port
    typedef enum logic [1:0] {
        WSEL_TPR    = 2'd0,
        WSEL_EOI    = 2'd1,
        WSEL_ENABLE = 2'd2,
        WSEL_SPARE  = 2'd3
    } wsel_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N = 15,
    parameter int W = $clog2(N + 1)
) (
    input  logic [N-1:0] vec_i,
    output logic [W-1:0] top_o
);

    // bit i stands for level i+1; 0 means the vector is empty
    always_comb begin
        top_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) top_o = W'(i + 1);
        end
    end

endmodule

// File: rtl/irq_level_store.sv
module irq_level_store #(
    parameter int N = 15,
    parameter int W = $clog2(N + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_prio_i,
    input  logic [W-1:0] take_prio_i,
    input  logic [W-1:0] retire_prio_i,
    output logic [N-1:0] pend_nxt_o,
    output logic [N-1:0] insvc_nxt_o
);

    logic [N-1:0] pend_q, insvc_q;
    logic [N-1:0] set_m, take_m, retire_m;

    // level value 0 decodes to no bit, so it acts as a no-op
    for (genvar g = 0; g < N; g++) begin : g_lvl
        assign set_m[g]    = (set_prio_i    == W'(g + 1));
        assign take_m[g]   = (take_prio_i   == W'(g + 1));
        assign retire_m[g] = (retire_prio_i == W'(g + 1));
    end

    assign pend_nxt_o  = (pend_q  & ~take_m)   | set_m;
    assign insvc_nxt_o = (insvc_q & ~retire_m) | take_m;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            insvc_q <= '0;
        end else begin
            pend_q  <= pend_nxt_o;
            insvc_q <= insvc_nxt_o;
        end
    end

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_pkg::*;
#(
    parameter int LEVELS = 15,
    parameter int PW     = $clog2(LEVELS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          msg_valid,
    input  logic [PW-1:0] msg_prio,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [PW-1:0] wr_data,
    input  logic          irq_ack,
    output logic          irq_req,
    output logic [PW-1:0] irq_prio
);

    localparam logic [PW-1:0] TOP_LEVEL = PW'(LEVELS);

    wsel_e         sel;
    dlv_state_e    state_q, state_d;
    logic [PW-1:0] tpr_q, tpr_nxt;
    logic          en_q, en_nxt;
    logic [PW-1:0] pend_top_q, insvc_top_q;
    logic [PW-1:0] pend_top_nxt, insvc_top_nxt;
    logic [PW-1:0] set_prio, take_prio, retire_prio;
    logic [LEVELS-1:0] pend_nxt, insvc_nxt;
    logic          do_tpr, do_eoi, do_en, accept, eligible_nxt;

    assign sel    = wsel_e'(wr_sel);
    assign do_tpr = wr_en && (sel == WSEL_TPR);
    assign do_eoi = wr_en && (sel == WSEL_EOI);
    assign do_en  = wr_en && (sel == WSEL_ENABLE);

    assign tpr_nxt = do_tpr ? wr_data : tpr_q;
    assign en_nxt  = do_en ? wr_data[0] : en_q;

    // acceptance filter: strictly above the threshold, within range
    assign accept      = msg_valid && (msg_prio > tpr_q) && (msg_prio <= TOP_LEVEL);
    assign set_prio    = accept ? msg_prio : '0;
    assign take_prio   = ((state_q == DLV_ASSERT) && irq_ack) ? pend_top_q : '0;
    assign retire_prio = do_eoi ? insvc_top_q : '0;

    irq_level_store #(.N(LEVELS), .W(PW)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_prio_i   (set_prio),
        .take_prio_i  (take_prio),
        .retire_prio_i(retire_prio),
        .pend_nxt_o   (pend_nxt),
        .insvc_nxt_o  (insvc_nxt)
    );

    irq_prio_enc #(.N(LEVELS), .W(PW)) u_pend_enc (
        .vec_i(pend_nxt),
        .top_o(pend_top_nxt)
    );

    irq_prio_enc #(.N(LEVELS), .W(PW)) u_insvc_enc (
        .vec_i(insvc_nxt),
        .top_o(insvc_top_nxt)
    );

    assign eligible_nxt = (pend_top_nxt > tpr_nxt) && (pend_top_nxt > insvc_top_nxt);

    // next-state: arm / arm_held / hold / release / drain / drain_held
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DLV_QUIET: begin
                if (eligible_nxt) state_d = en_nxt ? DLV_ASSERT : DLV_MASKED;
            end
            DLV_ASSERT: begin
                if (!eligible_nxt)  state_d = DLV_QUIET;
                else if (!en_nxt)   state_d = DLV_MASKED;
            end
            DLV_MASKED: begin
                if (!eligible_nxt)  state_d = DLV_QUIET;
                else if (en_nxt)    state_d = DLV_ASSERT;
            end
            default: state_d = DLV_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DLV_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tpr_q       <= '0;
            en_q        <= 1'b1;
            pend_top_q  <= '0;
            insvc_top_q <= '0;
        end else begin
            tpr_q       <= tpr_nxt;
            en_q        <= en_nxt;
            pend_top_q  <= pend_top_nxt;
            insvc_top_q <= insvc_top_nxt;
        end
    end

    always_comb begin
        irq_req  = (state_q == DLV_ASSERT);
        irq_prio = irq_req ? pend_top_q : '0;
    end

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_req,
    input logic [PW-1:0] irq_prio,
    input logic          irq_ack,
    input logic          wr_en,
    input logic [1:0]    wr_sel,
    input logic          en_q,
    input logic [PW-1:0] tpr_q,
    input logic [PW-1:0] insvc_top_q
);

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!irq_req && irq_prio == '0));

    a_r9_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> en_q);

    a_r10_above_tpr: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_prio > tpr_q));

    a_r5_above_service: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_prio > insvc_top_q));

    a_r4_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && !(wr_en && wr_sel == 2'd1)) |=> (insvc_top_q == $past(irq_prio)));

    a_r7_eoi_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && insvc_top_q == '0 && !(irq_req && irq_ack)) |=> (insvc_top_q == '0));

endmodule

bind irq_accept_unit irq_accept_chk #(.PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .irq_prio   (irq_prio),
    .irq_ack    (irq_ack),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .en_q       (en_q),
    .tpr_q      (tpr_q),
    .insvc_top_q(insvc_top_q)
);

// File: tb/irq_accept_unit_tb.sv
`timescale 1ns/1ps
module irq_accept_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       msg_valid = 1'b0;
    logic [3:0] msg_prio = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [3:0] wr_data = '0;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic [3:0] irq_prio;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic       req;
        logic [3:0] prio;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    irq_accept_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .msg_valid(msg_valid),
        .msg_prio (msg_prio),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .irq_ack  (irq_ack),
        .irq_req  (irq_req),
        .irq_prio (irq_prio)
    );

    // monitor: compares outputs against the scoreboard, away from the edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (irq_req !== e.req || irq_prio !== e.prio) begin
                n_bad++;
                $display("FAIL %s: req/prio actual %0b/%0d expected %0b/%0d",
                         e.tag, irq_req, irq_prio, e.req, e.prio);
            end
        end
    end

    // driver: one operation per cycle, expectation pushed after the edge
    task automatic op(input logic mv, input logic [3:0] mp, input logic ack,
                      input logic we, input logic [1:0] ws, input logic [3:0] wd,
                      input logic er, input logic [3:0] ep, input string tag);
        exp_t e;
        @(negedge clk);
        msg_valid = mv; msg_prio = mp; irq_ack = ack;
        wr_en = we; wr_sel = ws; wr_data = wd;
        @(posedge clk);
        #1;
        msg_valid = 1'b0; irq_ack = 1'b0; wr_en = 1'b0;
        e.req = er; e.prio = ep; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic msg(input logic [3:0] p, input logic er, input logic [3:0] ep, input string tag);
        op(1'b1, p, 1'b0, 1'b0, 2'd0, 4'd0, er, ep, tag);
    endtask

    task automatic ack(input logic er, input logic [3:0] ep, input string tag);
        op(1'b0, 4'd0, 1'b1, 1'b0, 2'd0, 4'd0, er, ep, tag);
    endtask

    task automatic wr(input logic [1:0] s, input logic [3:0] d, input logic er, input logic [3:0] ep, input string tag);
        op(1'b0, 4'd0, 1'b0, 1'b1, s, d, er, ep, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        op(1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 4'd0, 1'b0, 4'd0, "R1 reset idle");

        msg(4'd0, 1'b0, 4'd0, "R2 level zero dropped");
        msg(4'd4, 1'b1, 4'd4, "R3 first request");
        msg(4'd9, 1'b1, 4'd9, "R3 highest offered");
        ack(1'b0, 4'd0, "R4 lower pending withheld");
        msg(4'd12, 1'b1, 4'd12, "R5 preempt");
        ack(1'b0, 4'd0, "R4 nested service");
        msg(4'd12, 1'b0, 4'd0, "R4 equal to service withheld");
        wr(2'd1, 4'd0, 1'b1, 4'd12, "R6 finish releases pending");
        ack(1'b0, 4'd0, "R4 reenter service");
        wr(2'd1, 4'd0, 1'b0, 4'd0, "R6 finish leaves outer level");
        wr(2'd1, 4'd0, 1'b1, 4'd4, "R6 finish outer");
        ack(1'b0, 4'd0, "R4 ack level 4");
        wr(2'd1, 4'd0, 1'b0, 4'd0, "R6 finish last");
        wr(2'd1, 4'd0, 1'b0, 4'd0, "R7 finish with none in service");
        msg(4'd2, 1'b1, 4'd2, "R7 delivery unaffected");
        ack(1'b0, 4'd0, "R4 ack level 2");
        wr(2'd1, 4'd0, 1'b0, 4'd0, "R6 finish level 2");

        ack(1'b0, 4'd0, "R11 ack while idle");
        msg(4'd5, 1'b1, 4'd5, "R11 idle ack left state alone");
        wr(2'd2, 4'd0, 1'b0, 4'd0, "R9 disable drops request");
        msg(4'd8, 1'b0, 4'd0, "R9 accepted while disabled");
        ack(1'b0, 4'd0, "R11 ack while masked");
        wr(2'd2, 4'd1, 1'b1, 4'd8, "R9 reenable delivers held");
        ack(1'b0, 4'd0, "R4 ack level 8");
        wr(2'd1, 4'd0, 1'b1, 4'd5, "R6 finish exposes level 5");
        ack(1'b0, 4'd0, "R11 level 5 still pending after masked ack");
        wr(2'd1, 4'd0, 1'b0, 4'd0, "R6 finish level 5");

        msg(4'd7, 1'b1, 4'd7, "R8 first copy");
        msg(4'd7, 1'b1, 4'd7, "R8 second copy");
        ack(1'b0, 4'd0, "R8 single ack");
        wr(2'd1, 4'd0, 1'b0, 4'd0, "R8 merged copy not re-offered");

        wr(2'd0, 4'd6, 1'b0, 4'd0, "R10 threshold set");
        msg(4'd6, 1'b0, 4'd0, "R2 equal to threshold dropped");
        msg(4'd3, 1'b0, 4'd0, "R2 below threshold dropped");
        msg(4'd7, 1'b1, 4'd7, "R2 above threshold accepted");
        wr(2'd0, 4'd10, 1'b0, 4'd0, "R10 raised threshold holds");
        wr(2'd0, 4'd0, 1'b1, 4'd7, "R10 lowered threshold releases");
        ack(1'b0, 4'd0, "R2 dropped levels not pending");
        wr(2'd1, 4'd0, 1'b0, 4'd0, "R2 nothing left");

        wr(2'd0, 4'd14, 1'b0, 4'd0, "R10 threshold 14");
        msg(4'd15, 1'b1, 4'd15, "R2 top level accepted");
        ack(1'b0, 4'd0, "R4 ack top level");
        wr(2'd1, 4'd0, 1'b0, 4'd0, "R6 finish top level");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule